// File: doc/BRIEF.md
# Serial chain node for hashing-job dispatch

One node in a string of hashing devices that share a single serial data path. The host shifts one long frame through the whole string. The frame is a start marker followed by one job slot per node, in chain order. None of the nodes has an address. Each node watches its input for the start marker. It swallows the marker and takes the next slot as its own job. In that slot's bit times it sends its latest result downstream, followed by a fresh copy of the marker. The slot meant for the next node therefore arrives directly after a marker, so a node's job is set purely by its place in the string.

Once its slot has passed, the node relays every further bit with a single register of delay until chip select rises. The host receives all results at the far end of the string in chain order, within the same transfer that delivers the new jobs. A result that shows up at a given frame position identifies a particular board.

Each node keeps two job registers. The pending register fills from the serial slot. The active register feeds the hashing core. The pending job moves to active when the core reports completion, or at once if the core has no job yet. A completion with nothing pending keeps the old job and raises an idle flag in the following result. The node's logic advances only on serial bit strobes, so gaps between bits or bytes have no effect.

Top module: `chain_node`

## Requirements
- R1: After reset the serial output is 0, the job-valid output is 0, and no job is pending.
- R2: The start marker is the 16-bit value 0xA55A, received most significant bit first as 16 consecutive bits while the node is hunting. Any other 16-bit pattern starts nothing.
- R3: While hunting, each input bit appears at the output 16 bit strobes later. The bits of a matched marker are never sent on, and a node that has seen no input bits since chip select fell outputs 0.
- R4: The SLOT_BITS bits (default 128) that follow the marker are loaded into the pending job register, first bit at the most significant position. In a chain the k-th slot after the marker reaches node k.
- R5: During its slot the node outputs SLOT_BITS-16 result bits, most significant first, and then the marker 0xA55A.
- R6: The result word, from most significant bit down, is: job-valid, idle flag, two-bit nonce count, zero padding, nonce 1 (32 bits), then nonce 0 (32 bits, least significant byte last). It is sampled on the strobe that completes the marker.
- R7: After its slot the node copies each input bit to the output one strobe later, until chip select rises.
- R8: Chip select high returns the node to hunting, clears any partial marker match and drives the output to 0. A slot cut short by chip select is never promoted to active, and the next frame is handled normally.
- R9: A fully received slot becomes active at once when no job is active.
- R10: On a job-done pulse with a job pending, the pending job becomes active and the idle flag clears. On a job-done pulse with nothing pending, the active job stays and the idle flag is set.
- R11: At the far end of an N-node string, the results arrive back to back in chain order, starting 16+17*(N-1) strobes into the frame, followed by one marker.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_en | input | 1 | One-cycle strobe per serial bit (clock rising edge of the link) |
| cs_n | input | 1 | Active-low frame select; high ends the frame |
| din | input | 1 | Serial data from the upstream node or host |
| dout | output | 1 | Serial data to the downstream node or host |
| job_done | input | 1 | Pulse from the hashing core: current job finished |
| res_count | input | 2 | Number of nonces found (0 to 2) |
| res_nonce0 | input | 32 | First nonce found |
| res_nonce1 | input | 32 | Second nonce found |
| job_word | output | SLOT_BITS | Active job handed to the core |
| job_valid | output | 1 | An active job is present |

## Verification
A four-node string is driven with full frames. The bench checks each node's active job against its own slot, so a node that counted its position wrongly would show a neighbour's job. The returned stream is checked bit by bit: zeros before the first result, results in chain order, the marker regenerated once, and the trailing padding copied through. A design that relayed the marker would make every downstream node claim the wrong slot. One with the wrong delay would shift the results out of place. Two cut-off cases are covered: a frame stopped partway through a marker, where stale marker bits would leak into the next frame's output, and a frame stopped partway through a slot, where a half-loaded job would be promoted or the node would stay in its claim state. Job-done pulses with and without a pending job check that the job is kept and that the idle flag appears in the next result.

// File: rtl/chain_pkg.sv
package chain_pkg;
    typedef enum logic [1:0] {
        ST_HUNT  = 2'd0,
        ST_CLAIM = 2'd1,
        ST_FWD   = 2'd2
    } link_state_t;
endpackage

// File: rtl/chain_prefix_det.sv
module chain_prefix_det #(
    parameter int                  PREFIX_W = 16,
    parameter logic [PREFIX_W-1:0] PREFIX   = 16'hA55A
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_en,
    input  logic cs_n,
    input  logic hunt,
    input  logic din,
    output logic match,
    output logic oldest
);
    typedef struct packed {
        logic [PREFIX_W-1:0] sr;
    } det_t;

    det_t q, d;
    logic [PREFIX_W-1:0] window;

    always_comb begin
        d      = q;
        window = {q.sr[PREFIX_W-2:0], din};
        match  = bit_en && !cs_n && hunt && (window == PREFIX);
        oldest = q.sr[PREFIX_W-1];
        if (cs_n) begin
            d.sr = '0;
        end else if (bit_en && hunt) begin
            d.sr = match ? '0 : window;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R8: a raised select leaves no partial match behind
    p_clear_on_deselect_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (q.sr == '0));
endmodule

// File: rtl/chain_link.sv
module chain_link
    import chain_pkg::*;
#(
    parameter int                  SLOT_BITS = 128,
    parameter int                  PREFIX_W  = 16,
    parameter logic [PREFIX_W-1:0] PREFIX    = 16'hA55A,
    localparam int                 RES_BITS  = SLOT_BITS - PREFIX_W,
    localparam int                 CNT_W     = $clog2(SLOT_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                bit_en,
    input  logic                cs_n,
    input  logic                din,
    input  logic                match,
    input  logic                oldest,
    input  logic [RES_BITS-1:0] res_word,
    output logic                hunt,
    output logic                cap_start,
    output logic                cap_en,
    output logic                cap_bit,
    output logic                cap_done,
    output logic                dout
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOT_BITS - 1);

    typedef struct packed {
        link_state_t          st;
        logic [CNT_W-1:0]     cnt;
        logic [SLOT_BITS-1:0] osr;
        logic                 dout;
    } link_t;

    link_t q, d;

    assign hunt = (q.st == ST_HUNT);
    assign dout = q.dout;

    always_comb begin
        d         = q;
        cap_start = 1'b0;
        cap_en    = 1'b0;
        cap_done  = 1'b0;
        cap_bit   = din;
        if (cs_n) begin
            d.st   = ST_HUNT;
            d.cnt  = '0;
            d.dout = 1'b0;
        end else if (bit_en) begin
            case (q.st)
                ST_HUNT: begin
                    d.dout = oldest;
                    if (match) begin
                        d.st      = ST_CLAIM;
                        d.cnt     = '0;
                        d.osr     = {res_word, PREFIX};
                        cap_start = 1'b1;
                    end
                end
                ST_CLAIM: begin
                    d.dout = q.osr[SLOT_BITS-1];
                    d.osr  = {q.osr[SLOT_BITS-2:0], 1'b0};
                    d.cnt  = q.cnt + 1'b1;
                    cap_en = 1'b1;
                    if (q.cnt == LAST) begin
                        d.st     = ST_FWD;
                        cap_done = 1'b1;
                    end
                end
                default: d.dout = din;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '{st: ST_HUNT, cnt: '0, osr: '0, dout: 1'b0};
        else        q <= d;
    end

    // R8: deselect forces hunting and a quiet output
    p_deselect_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (!dout && hunt));
    // R7: relay stage copies the input with one strobe of delay
    p_forward_copy_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_FWD && bit_en && !cs_n) |=> (dout == $past(din)));
    // R2: a claim can only start from hunting on a marker match
    p_claim_entry_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st != ST_CLAIM) ##1 (q.st == ST_CLAIM) |-> $past(match));
endmodule

// File: rtl/chain_job_buf.sv
module chain_job_buf #(
    parameter int SLOT_BITS = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cap_start,
    input  logic                 cap_en,
    input  logic                 cap_bit,
    input  logic                 cap_done,
    input  logic                 job_done,
    output logic [SLOT_BITS-1:0] job_word,
    output logic                 job_valid,
    output logic                 idle
);
    typedef struct packed {
        logic [SLOT_BITS-1:0] pend;
        logic                 full;
        logic [SLOT_BITS-1:0] act;
        logic                 vld;
        logic                 idle;
    } buf_t;

    buf_t q, d;

    assign job_word  = q.act;
    assign job_valid = q.vld;
    assign idle      = q.idle;

    always_comb begin
        d = q;
        if (cap_start) d.full = 1'b0;
        if (cap_en)    d.pend = {q.pend[SLOT_BITS-2:0], cap_bit};
        if (cap_done)  d.full = 1'b1;
        if (q.full && (job_done || !q.vld)) begin
            d.act  = q.pend;
            d.vld  = 1'b1;
            d.full = 1'b0;
            d.idle = 1'b0;
        end else if (job_done) begin
            d.idle = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    // R4: a completed slot is always held as pending
    p_full_after_slot_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |=> q.full);
    // R10: completion with a pending job hands it over
    p_promote_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (job_done && q.full) |=> (job_valid && !idle && job_word == $past(q.pend)));
    // R10: completion with nothing pending keeps the job and flags idle
    p_keep_and_flag_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (job_done && !q.full) |=> (idle && job_word == $past(job_word)));
endmodule

// File: rtl/chain_node.sv
module chain_node
    import chain_pkg::*;
#(
    parameter int                  SLOT_BITS = 128,
    parameter int                  PREFIX_W  = 16,
    parameter logic [PREFIX_W-1:0] PREFIX    = 16'hA55A,
    parameter int                  NONCE_W   = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 bit_en,
    input  logic                 cs_n,
    input  logic                 din,
    output logic                 dout,
    input  logic                 job_done,
    input  logic [1:0]           res_count,
    input  logic [NONCE_W-1:0]   res_nonce0,
    input  logic [NONCE_W-1:0]   res_nonce1,
    output logic [SLOT_BITS-1:0] job_word,
    output logic                 job_valid
);
    localparam int RES_BITS = SLOT_BITS - PREFIX_W;
    localparam int PAD_BITS = RES_BITS - 4 - 2 * NONCE_W;

    logic                hunt, match, oldest;
    logic                cap_start, cap_en, cap_bit, cap_done;
    logic                idle;
    logic [RES_BITS-1:0] res_word;

    generate
        if (PAD_BITS > 0) begin : g_pad
            assign res_word = {job_valid, idle, res_count, {PAD_BITS{1'b0}},
                               res_nonce1, res_nonce0};
        end else begin : g_nopad
            assign res_word = {job_valid, idle, res_count, res_nonce1, res_nonce0};
        end
    endgenerate

    chain_prefix_det #(.PREFIX_W(PREFIX_W), .PREFIX(PREFIX)) u_det (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cs_n(cs_n), .hunt(hunt),
        .din(din), .match(match), .oldest(oldest)
    );

    chain_link #(.SLOT_BITS(SLOT_BITS), .PREFIX_W(PREFIX_W), .PREFIX(PREFIX)) u_link (
        .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cs_n(cs_n), .din(din),
        .match(match), .oldest(oldest), .res_word(res_word), .hunt(hunt),
        .cap_start(cap_start), .cap_en(cap_en), .cap_bit(cap_bit),
        .cap_done(cap_done), .dout(dout)
    );

    chain_job_buf #(.SLOT_BITS(SLOT_BITS)) u_buf (
        .clk(clk), .rst_n(rst_n), .cap_start(cap_start), .cap_en(cap_en),
        .cap_bit(cap_bit), .cap_done(cap_done), .job_done(job_done),
        .job_word(job_word), .job_valid(job_valid), .idle(idle)
    );

    // R1: nothing leaves the node while it is deselected
    p_quiet_deselected_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $past(cs_n) |-> !dout);
endmodule

// File: tb/test_chain_node.sv
module test_chain_node;
    localparam int S    = 128;
    localparam int N    = 4;
    localparam int R    = S - 16;
    localparam int FB   = 16 + N * S + 32;
    localparam int H0   = 16 + 17 * (N - 1);
    localparam logic [15:0] MARK = 16'hA55A;
    // seed[23:8], count[2:1], done[0]
    localparam logic [23:0] VEC [4] = '{24'h000304, 24'h000503, 24'h000901, 24'h000C04};

    logic clk = 0, rst_n = 0, bit_en = 0, cs_n = 1, job_done = 0;
    logic ch [0:N];
    logic [1:0]  cnt_i [N];
    logic [31:0] n0_i [N], n1_i [N];
    logic [S-1:0] jw [N];
    logic jv [N];
    logic hin [0:FB-1];
    logic hout [0:FB-1];
    logic [S-1:0] m_act [N], m_pendv [N];
    logic m_vld [N], m_idle [N], m_pend [N];
    int checks = 0, errors = 0;
    bit finished = 0;
    logic host_din = 0;

    always #2.5 clk = ~clk;
    assign ch[0] = host_din;

    for (genvar g = 0; g < N; g++) begin : g_node
        chain_node #(.SLOT_BITS(S)) i_chain_node (
            .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .cs_n(cs_n), .din(ch[g]),
            .dout(ch[g+1]), .job_done(job_done), .res_count(cnt_i[g]),
            .res_nonce0(n0_i[g]), .res_nonce1(n1_i[g]), .job_word(jw[g]),
            .job_valid(jv[g])
        );
    end

    task automatic chk(input bit ok, input string req, input logic [S-1:0] act,
                       input logic [S-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [S-1:0] slot_fn(input int seed, input int k);
        logic [S-1:0] r;
        for (int w = 0; w < S / 32; w++) r[w*32 +: 32] = 32'(32'h9E3779B9 * (seed * 13 + k * 7 + w + 1));
        return r;
    endfunction

    task automatic set_core(input int seed, input logic [1:0] c);
        for (int k = 0; k < N; k++) begin
            cnt_i[k] = c;
            n0_i[k]  = 32'(32'h11111111 * (seed + k + 1)) & 32'h1F1F1F1F;
            n1_i[k]  = 32'(32'h01030507 * (seed + 3 * k + 2)) & 32'h1F1F1F1F;
        end
    endtask

    task automatic build(input int seed);
        for (int i = 0; i < FB; i++) hin[i] = (i % 3 == 0);
        for (int i = 0; i < 16; i++) hin[i] = MARK[15-i];
        for (int k = 0; k < N; k++) begin
            logic [S-1:0] s = slot_fn(seed, k);
            for (int j = 0; j < S; j++) hin[16 + k*S + j] = s[S-1-j];
        end
    endtask

    task automatic send(input int nbits);
        @(negedge clk) cs_n = 0;
        for (int i = 0; i < nbits; i++) begin
            @(negedge clk); host_din = hin[i]; bit_en = 1;
            @(negedge clk); bit_en = 0; hout[i] = ch[N];
        end
        @(negedge clk) cs_n = 1; host_din = 0;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_stream();
        bit z = 1;
        logic [15:0] mk;
        for (int h = 0; h < H0; h++) if (hout[h] !== 1'b0) z = 0;
        chk(z, "R3 quiet lead-in and no relayed marker", S'(!z), 0);
        for (int k = 0; k < N; k++) begin
            logic [S-1:0] got = '0, exp;
            exp = S'({m_vld[k], m_idle[k], cnt_i[k], {(R-68){1'b0}}, n1_i[k], n0_i[k]});
            for (int j = 0; j < R; j++) got = {got[S-2:0], hout[H0 + k*R + j]};
            chk(got === exp, $sformatf("R5 R6 R11 result of node %0d", k), got, exp);
        end
        mk = '0;
        for (int j = 0; j < 16; j++) mk = {mk[14:0], hout[H0 + N*R + j]};
        chk(mk === MARK, "R5 regenerated marker", S'(mk), S'(MARK));
        z = 1;
        for (int h = H0 + N*R + 16; h < FB; h++) if (hout[h] !== hin[h-(N-1)]) z = 0;
        chk(z, "R7 trailing bits relayed", S'(!z), 0);
    endtask

    task automatic model_frame(input int seed);
        for (int k = 0; k < N; k++) begin
            m_pend[k] = 1; m_pendv[k] = slot_fn(seed, k);
            if (!m_vld[k]) begin m_act[k] = m_pendv[k]; m_vld[k] = 1; m_pend[k] = 0; m_idle[k] = 0; end
        end
    endtask

    task automatic pulse_done();
        @(negedge clk) job_done = 1;
        @(negedge clk) job_done = 0;
        @(negedge clk);
        for (int k = 0; k < N; k++) begin
            if (m_pend[k]) begin m_act[k] = m_pendv[k]; m_vld[k] = 1; m_pend[k] = 0; m_idle[k] = 0; end
            else m_idle[k] = 1;
        end
    endtask

    task automatic check_jobs(input string req);
        for (int k = 0; k < N; k++) begin
            chk(jv[k] === m_vld[k], $sformatf("%s valid node %0d", req, k), S'(jv[k]), S'(m_vld[k]));
            chk(jw[k] === m_act[k], $sformatf("%s job node %0d", req, k), jw[k], m_act[k]);
        end
    endtask

    initial begin
        for (int k = 0; k < N; k++) begin
            m_vld[k] = 0; m_idle[k] = 0; m_pend[k] = 0; m_act[k] = '0; m_pendv[k] = '0;
        end
        set_core(0, 2'd0);
        repeat (4) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        for (int k = 0; k < N; k++) begin
            chk(ch[k+1] === 1'b0, "R1 output after reset", S'(ch[k+1]), 0);
            chk(jv[k] === 1'b0, "R1 valid after reset", S'(jv[k]), 0);
        end
        // table-driven frames
        for (int v = 0; v < 4; v++) begin
            int seed = int'(VEC[v][23:8]);
            set_core(seed, VEC[v][2:1]);
            build(seed);
            send(FB);
            check_stream();
            model_frame(seed);
            check_jobs("R4 R9 positional capture");
            if (VEC[v][0]) begin
                pulse_done();
                check_jobs("R10 handoff");
            end
        end
        // R10: completions with and without a pending job
        pulse_done();
        pulse_done();
        check_jobs("R10 keep job when nothing pending");
        set_core(40, 2'd1);
        build(40);
        send(FB);
        check_stream();
        model_frame(40);
        // R2: wrong marker starts nothing; R3 hunting delay through all nodes
        for (int i = 0; i < FB; i++) hin[i] = (i % 3 == 0);
        for (int i = 0; i < 16; i++) hin[i] = logic'(16'hA55B >> (15 - i));
        send(FB);
        begin
            bit z = 1;
            for (int h = 17 * N - 1; h < FB; h++) if (hout[h] !== hin[h - (17 * N - 1)]) z = 0;
            chk(z, "R2 R3 unmatched frame only delayed", S'(!z), 0);
        end
        check_jobs("R2 no capture on wrong marker");
        // R8: frame cut inside the marker, then a full frame
        build(51);
        send(10);
        set_core(51, 2'd2);
        send(FB);
        check_stream();
        model_frame(51);
        check_jobs("R8 after partial marker");
        // R8: frame cut inside node 0's slot
        build(63);
        send(16 + S / 2);
        m_pend[0] = 0;
        pulse_done();
        check_jobs("R8 cut slot not promoted");
        set_core(77, 2'd1);
        build(77);
        send(FB);
        check_stream();
        model_frame(77);
        check_jobs("R8 next frame after cut slot");
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog R1 actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule